// File: doc/BRIEF.md
# Two-Wire Bus Core with Tick-Timed Master Clock and Deferred Slave Inhibit

This block is a compact two-wire serial bus core with open-drain outputs. It can act as a clock master or as an address-responding slave. As a master it produces SCL without any divider of its own. It counts single-cycle overflow strobes from one of four free-running timers that sit outside the block. A 2-bit source field picks the timer. The low phase lasts two strobe periods and the high phase lasts one, so the bit rate is about a third of the selected overflow rate. The high phase is counted only after the released line is seen high, which lets another device stretch the clock.

As a slave the core synchronises both lines and detects START and STOP. It shifts in a 7-bit address and a direction bit, then acknowledges its own address by pulling SDA low for the ninth clock. A successful address match raises a level interrupt. So does the STOP that closes an acknowledged transfer. Software clears the interrupt with a clear strobe. An inhibit control makes the slave refuse every address and stay silent, while it keeps following the bus. The inhibit value is captured only at a START, so a transfer already under way finishes with its interrupts intact.

Top module: `twi_tick_core`

## Requirements
- R1: While `cfg_enable` is 0 the core drives neither line (`scl_oe` and `sda_oe` stay 0) and raises no interrupt, even with `mst_run` high and a matching address on the bus; after reset all three outputs are 0.
- R2: `cfg_src_sel` value k selects strobe `tick_in[k]` (0, 1, 2, 3 map to bits 0, 1, 2, 3), and in master mode each SCL low phase lasts exactly two periods of the selected strobe.
- R3: In master mode, with no stretching, each SCL high phase lasts exactly one strobe period, so one bit takes three periods.
- R4: After releasing SCL the master does not drive it low again while the line is held low externally, and it starts counting the high phase only once SCL is sampled high.
- R5: A START is SDA falling while SCL is high and a STOP is SDA rising while SCL is high, both taken after two-flop synchronisation; after a START the slave shifts in eight bits on SCL rising edges, most significant first, the first seven being the address.
- R6: When the received address equals `SLV_ADDR` (default 7'h5A) and the transfer is not inhibited, `sda_oe` goes high from the SCL fall after the eighth bit to the SCL fall after the ninth, and `slv_irq` is set.
- R7: A non-matching address (including the bit-reversed own address) gets no acknowledge and no interrupt, and the following STOP raises no interrupt.
- R8: When `cfg_inhibit` is 1 at a START, that transfer is refused for every address, with no acknowledge and no interrupt, while the bus is still followed so the next uninhibited START is served.
- R9: Setting `cfg_inhibit` after a START does not affect that transfer: a matching address is still acknowledged, and its closing STOP sets `slv_irq`.
- R10: `slv_irq` is a level that stays 1 until a one-cycle `irq_clr` pulse clears it.
- R11: Slave operation needs no strobe: it works with every `tick_in` bit held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Enables master and slave handling |
| cfg_inhibit | input | 1 | Refuse slave addresses, captured at each START |
| cfg_src_sel | input | 2 | Strobe source select |
| mst_run | input | 1 | Request to generate the master clock |
| tick_in | input | 4 | Timer overflow strobes, one cycle wide |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| irq_clr | input | 1 | Clears the slave interrupt |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| slv_irq | output | 1 | Slave event interrupt level |

## Verification
The master clock is run from each of the four sources in turn, and each source has a different period (10, 14, 22 and 6 cycles). An exact low width of 2P and high width of P therefore shows both that the right strobe was selected and that the tick counts are right. A stretch run holds SCL low after release, which separates a master that waits for the line from one that blindly counts ticks. Slave transfers use the own address, its bit-reverse, inhibit set before the START, and inhibit set in the middle of the address. These separate address matching and bit order from the moment the inhibit is captured. A transfer with the core disabled shows that nothing is driven.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [1:0] {
      M_IDLE,
      M_LOW,
      M_REL,
      M_HIGH
   } mst_state_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_ACKWAIT,
      S_ACK,
      S_BUSY
   } slv_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 2");
   end

   for (genvar w = 0; w < WIDTH; w++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d_in[w]};
      end
      assign q_out[w] = chain[STAGES-1];
   end
endmodule

// File: rtl/twi_tick_select.sv
module twi_tick_select #(
   parameter int NUM_SRC = 4,
   localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] tick_in,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);
   if (NUM_SRC < 2) begin : g_bad_src
      $error("twi_tick_select: NUM_SRC must be at least 2");
   end

   logic [NUM_SRC-1:0] hit;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = tick_in[i] && (sel == SEL_W'(i));
   end
   assign tick = |hit;
endmodule

// File: rtl/twi_master_clk.sv
module twi_master_clk
   import twi_pkg::*;
#(
   parameter int LOW_TICKS  = 2,
   parameter int HIGH_TICKS = 1,
   localparam int MAXT      = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS,
   localparam int CNT_W     = (MAXT > 1) ? $clog2(MAXT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic run,
   input  logic tick,
   input  logic scl_s,
   output logic scl_oe
);
   if (LOW_TICKS < 1 || HIGH_TICKS < 1) begin : g_bad_ticks
      $error("twi_master_clk: tick counts must be at least 1");
   end

   localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_TICKS - 1);
   localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_TICKS - 1);

   mst_state_e       st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= M_IDLE;
         cnt    <= '0;
         scl_oe <= 1'b0;
      end else if (!en) begin
         st     <= M_IDLE;
         cnt    <= '0;
         scl_oe <= 1'b0;
      end else begin
         unique case (st)
            M_IDLE: if (run && tick) begin
               st     <= M_LOW;
               cnt    <= '0;
               scl_oe <= 1'b1;
            end
            M_LOW: if (tick) begin
               if (cnt == LOW_LAST) begin
                  st     <= M_REL;
                  cnt    <= '0;
                  scl_oe <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            M_REL: if (scl_s) st <= M_HIGH;
            M_HIGH: if (tick) begin
               if (cnt == HIGH_LAST) begin
                  cnt    <= '0;
                  st     <= run ? M_LOW : M_IDLE;
                  scl_oe <= run;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= M_IDLE;
         endcase
      end
   end

   // R2
   low_starts_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> $past(tick));
   // R3
   low_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_oe) && $past(en)) |-> $past(tick));
endmodule

// File: rtl/twi_slave_mon.sv
module twi_slave_mon
   import twi_pkg::*;
#(
   parameter int          ADDR_W   = 7,
   parameter logic [ADDR_W-1:0] SLV_ADDR = 7'h5A,
   localparam int         BITS     = ADDR_W + 1,
   localparam int         BCNT_W   = $clog2(BITS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic inhibit,
   input  logic scl_s,
   input  logic sda_s,
   input  logic irq_clr,
   output logic sda_oe,
   output logic irq
);
   slv_state_e        st;
   logic              scl_q, sda_q, inh_eff, acked;
   logic [ADDR_W-1:0] addr_q;
   logic [BCNT_W-1:0] bcnt;

   wire scl_rise  = scl_s & ~scl_q;
   wire scl_fall  = ~scl_s & scl_q;
   wire start_det = scl_s & scl_q & sda_q & ~sda_s;
   wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   wire addr_ok   = (addr_q == SLV_ADDR) && !inh_eff;

   logic irq_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         inh_eff <= 1'b0;
         acked   <= 1'b0;
         addr_q  <= '0;
         bcnt    <= '0;
         sda_oe  <= 1'b0;
         irq_set <= 1'b0;
      end else begin
         irq_set <= 1'b0;
         if (!en) begin
            st     <= S_IDLE;
            acked  <= 1'b0;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            st      <= S_ADDR;
            bcnt    <= '0;
            inh_eff <= inhibit;
            acked   <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            st      <= S_IDLE;
            sda_oe  <= 1'b0;
            irq_set <= acked;
            acked   <= 1'b0;
         end else begin
            unique case (st)
               S_ADDR: if (scl_rise) begin
                  if (bcnt < BCNT_W'(ADDR_W)) addr_q <= {addr_q[ADDR_W-2:0], sda_s};
                  bcnt <= bcnt + 1'b1;
                  if (bcnt == BCNT_W'(BITS - 1)) st <= S_ACKWAIT;
               end
               S_ACKWAIT: if (scl_fall) begin
                  st      <= S_ACK;
                  sda_oe  <= addr_ok;
                  acked   <= addr_ok;
                  irq_set <= addr_ok;
               end
               S_ACK: if (scl_fall) begin
                  st     <= S_BUSY;
                  sda_oe <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq <= 1'b0;
      else if (irq_set) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
   end

   // R6
   ack_on_scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall));
   // R10
   irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/twi_tick_core.sv
module twi_tick_core #(
   parameter int         NUM_SRC     = 4,
   parameter int         SYNC_STAGES = 2,
   parameter int         LOW_TICKS   = 2,
   parameter int         HIGH_TICKS  = 1,
   parameter logic [6:0] SLV_ADDR    = 7'h5A,
   localparam int        SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic               cfg_inhibit,
   input  logic [SEL_W-1:0]   cfg_src_sel,
   input  logic               mst_run,
   input  logic [NUM_SRC-1:0] tick_in,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic               irq_clr,
   output logic               scl_oe,
   output logic               sda_oe,
   output logic               slv_irq
);
   logic       tick_sel;
   logic [1:0] lines_s;

   twi_tick_select #(.NUM_SRC(NUM_SRC)) u_sel (
      .tick_in (tick_in),
      .sel     (cfg_src_sel),
      .tick    (tick_sel)
   );

   twi_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({sda_in, scl_in}),
      .q_out (lines_s)
   );

   twi_master_clk #(.LOW_TICKS(LOW_TICKS), .HIGH_TICKS(HIGH_TICKS)) u_mst (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg_enable),
      .run    (mst_run),
      .tick   (tick_sel),
      .scl_s  (lines_s[0]),
      .scl_oe (scl_oe)
   );

   twi_slave_mon #(.ADDR_W(7), .SLV_ADDR(SLV_ADDR)) u_slv (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_enable),
      .inhibit (cfg_inhibit),
      .scl_s   (lines_s[0]),
      .sda_s   (lines_s[1]),
      .irq_clr (irq_clr),
      .sda_oe  (sda_oe),
      .irq     (slv_irq)
   );

   // R1
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/twi_tick_core_test.sv
module twi_tick_core_test;
   localparam int CLK_PERIOD = 10;
   localparam int PER [4] = '{10, 14, 22, 6};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_enable = 1'b0, cfg_inhibit = 1'b0, mst_run = 1'b0, irq_clr = 1'b0;
   logic [1:0] cfg_src_sel = 2'd0;
   logic [3:0] tick_in = '0;
   logic       scl_drv = 1'b1, sda_drv = 1'b1, tick_on = 1'b0;
   logic       scl_oe, sda_oe, slv_irq;
   wire        scl_in = scl_drv & ~scl_oe;
   wire        sda_in = sda_drv & ~sda_oe;

   int n_run = 0, n_fail = 0, cyc = 0;
   logic oe_seen = 1'b0, irq_seen = 1'b0;

   twi_tick_core uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_inhibit(cfg_inhibit),
      .cfg_src_sel(cfg_src_sel), .mst_run(mst_run), .tick_in(tick_in),
      .scl_in(scl_in), .sda_in(sda_in), .irq_clr(irq_clr),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .slv_irq(slv_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      for (int i = 0; i < 4; i++) tick_in[i] <= tick_on && ((cyc % PER[i]) == 0);
      if (scl_oe || sda_oe) oe_seen <= 1'b1;
      if (slv_irq) irq_seen <= 1'b1;
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1; wait_n(1); irq_clr = 1'b0; wait_n(1);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; scl_drv = 1'b1; wait_n(8);
      sda_drv = 1'b0; wait_n(8);
      scl_drv = 1'b0; wait_n(4);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; wait_n(4);
      scl_drv = 1'b1; wait_n(8);
      sda_drv = 1'b1; wait_n(8);
   endtask

   task automatic send_bit(logic b);
      sda_drv = b; wait_n(4);
      scl_drv = 1'b1; wait_n(8);
      scl_drv = 1'b0; wait_n(4);
   endtask

   task automatic send_addr(logic [6:0] a, output logic ackd, input logic inh_mid = 1'b0);
      logic [7:0] b;
      b = {a, 1'b0};
      for (int i = 7; i >= 0; i--) begin
         if (inh_mid && i == 4) cfg_inhibit = 1'b1;
         send_bit(b[i]);
      end
      sda_drv = 1'b1; wait_n(4);
      scl_drv = 1'b1; wait_n(4);
      ackd = (sda_in == 1'b0);
      wait_n(4);
      scl_drv = 1'b0; wait_n(4);
   endtask

   task automatic measure(int sel);
      int lo, hi;
      cfg_src_sel = 2'(sel); mst_run = 1'b1;
      while (!scl_oe) wait_n(1);
      while (scl_oe) wait_n(1);
      while (!scl_oe) wait_n(1);
      lo = 0; while (scl_oe) begin lo++; wait_n(1); end
      hi = 0; while (!scl_oe) begin hi++; wait_n(1); end
      check("R2 low width", lo, 2 * PER[sel]);
      check("R3 high width", hi, PER[sel]);
      mst_run = 1'b0; wait_n(80);
   endtask

   task automatic t_sources();
      tick_on = 1'b1; cfg_enable = 1'b1;
      for (int s = 0; s < 4; s++) measure(s);
   endtask

   task automatic t_stretch();
      int n; logic redrive;
      cfg_src_sel = 2'd3; mst_run = 1'b1;
      while (!scl_oe) wait_n(1);
      scl_drv = 1'b0;
      while (scl_oe) wait_n(1);
      redrive = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (scl_oe) redrive = 1'b1;
         wait_n(1);
      end
      check("R4 no redrive while held", int'(redrive), 0);
      scl_drv = 1'b1;
      n = 0; while (!scl_oe && n < 200) begin n++; wait_n(1); end
      check("R4 high counted after release", int'(n >= 3 && n <= PER[3] + 4), 1);
      mst_run = 1'b0; wait_n(60);
      tick_on = 1'b0;
   endtask

   task automatic t_match();
      logic ackd;
      bus_start(); send_addr(7'h5A, ackd);
      check("R6 ack own address", int'(ackd), 1);
      check("R11 ack with ticks off", int'(tick_in != 0), 0);
      check("R6 irq on match", int'(slv_irq), 1);
      pulse_clr();
      bus_stop();
      check("R5 stop closes acked transfer irq", int'(slv_irq), 1);
      wait_n(20);
      check("R10 irq held", int'(slv_irq), 1);
      pulse_clr();
      check("R10 irq cleared", int'(slv_irq), 0);
   endtask

   task automatic t_mismatch();
      logic ackd;
      irq_seen = 1'b0;
      bus_start(); send_addr(7'h2D, ackd);
      check("R7 reversed addr nack", int'(ackd), 0);
      bus_stop();
      check("R7 no irq", int'(irq_seen), 0);
   endtask

   task automatic t_inhibit_mid();
      logic ackd;
      bus_start(); send_addr(7'h5A, ackd, 1'b1);
      check("R9 ack despite late inhibit", int'(ackd), 1);
      check("R9 irq despite late inhibit", int'(slv_irq), 1);
      pulse_clr();
      bus_stop();
      check("R9 stop irq despite inhibit", int'(slv_irq), 1);
      pulse_clr();
   endtask

   task automatic t_inhibit_active();
      logic ackd;
      cfg_inhibit = 1'b1; irq_seen = 1'b0;
      bus_start(); send_addr(7'h5A, ackd);
      check("R8 nack when inhibited", int'(ackd), 0);
      bus_stop();
      check("R8 no irq when inhibited", int'(irq_seen), 0);
      cfg_inhibit = 1'b0;
      bus_start(); send_addr(7'h5A, ackd);
      check("R8 served after inhibit cleared", int'(ackd), 1);
      bus_stop(); pulse_clr();
   endtask

   task automatic t_disabled();
      logic ackd;
      cfg_enable = 1'b0; tick_on = 1'b1; mst_run = 1'b1;
      oe_seen = 1'b0; irq_seen = 1'b0;
      bus_start(); send_addr(7'h5A, ackd); bus_stop();
      wait_n(100);
      check("R1 no drive when disabled", int'(oe_seen), 0);
      check("R1 no irq when disabled", int'(irq_seen), 0);
      mst_run = 1'b0; tick_on = 1'b0;
   endtask

   initial begin
      wait_n(5); rst_n = 1'b1; wait_n(2);
      check("R1 reset scl_oe", int'(scl_oe), 0);
      check("R1 reset sda_oe", int'(sda_oe), 0);
      check("R1 reset irq", int'(slv_irq), 0);
      t_sources();
      t_stretch();
      t_match();
      t_mismatch();
      t_inhibit_mid();
      t_inhibit_active();
      t_disabled();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule